// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block puts a small configuration register space behind two neighbouring byte-wide I/O addresses. The lower address is the index port and selects a register. The address just above it is the data port and reads or writes that register. A strap input, sampled while reset is held, chooses one of two base addresses. The register space is closed after reset. It opens only when the opening key byte is written to the index port on two index writes in a row. A separate closing key written to the index port shuts it again.

When the space is open, a logical-device selector decides which device's register bank the upper indices reach. Identification bytes (device ID, revision, manufacturer ID) are fixed and read-only. Every index at or above the window base is passed out on a register-window port. That port carries the selected device number, the index, the write data and read and write strobes, so that the devices behind it can implement their own registers. Host read data is combinational, and writes take effect at the next rising clock edge.

Top module: `keyed_cfg_port`

## Requirements
- R1: The index port sits at 0x2E when the strap input was low during reset and at 0x4E when it was high. The data port sits at the index port address plus one. Changing the strap after reset has no effect. Writes to any other address are ignored, and reads from any other address return 0xFF.
- R2: The register space opens only after two index-port writes of 0x87 in a row. `cfg_mode` goes high at the clock edge that takes the second of these writes.
- R3: While closed, an index-port write of any value other than 0x87 restarts the key sequence. Data-port accesses do not affect the sequence.
- R4: While closed, data-port writes have no effect: no window strobe fires and the device selector does not change. Reads from either port return 0xFF.
- R5: While open, an index-port write of 0xAA closes the space at that clock edge and leaves the index register unchanged. Any other index-port write loads the index register.
- R6: Each time the space opens, the index register is 0x00. While open, an index-port read returns the current index.
- R7: Index 0x07 holds the logical-device selector. It can be written and read while open, it is 0x00 after reset, and it keeps its value across closing and reopening.
- R8: Indices 0x20/0x21 read the device ID (high byte, then low byte), 0x22 reads the revision, and 0x23/0x24 read the manufacturer ID (high byte, then low byte; 0x1934 by default). Writes to these indices have no effect.
- R9: While open, an access at an index of 0x30 or above raises `win_we` (data-port write) or `win_re` (data-port read) during the same cycle, with `win_ldn`, `win_idx` and `win_wdata` valid. The read data is `win_rdata`. The strobes never fire at lower indices.
- R10: Any other index below 0x30 reads as 0x00 while open, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the strap is sampled while it is low |
| strap_alt | input | 1 | Base address select: 0 gives 0x2E, 1 gives 0x4E |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational, 0xFF when nothing responds |
| cfg_mode | output | 1 | High while the register space is open |
| win_ldn | output | 8 | Selected logical-device number |
| win_idx | output | 8 | Current index register |
| win_wdata | output | 8 | Write data for the register window |
| win_we | output | 1 | Window write strobe |
| win_re | output | 1 | Window read strobe |
| win_rdata | input | 8 | Read data returned by the selected device |

## Verification
The bench uses the default base addresses, key bytes, selector index and window base. It overrides the device ID with 0x5A3C and the revision with 0x2B, so that every identification byte differs from the others and from 0x00 and 0xFF. The bench resets the block once with the strap low and once with it high, which covers both base addresses and a strap change after reset. Its window responder returns a value made from the device number and the index, so a wrong selector or a wrong index shows up in the read data.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] NO_RESPONSE = 8'hFF;
  localparam logic [7:0] ID_FIRST    = 8'h20;
  localparam int         ID_COUNT    = 5;

  // True when an index falls into the exported register window.
  function automatic logic in_window(input logic [7:0] idx, input logic [7:0] base);
    return idx >= base;
  endfunction

  // Identification byte at position pos counted from ID_FIRST.
  function automatic logic [7:0] id_byte(input int pos, input logic [15:0] dev,
                                         input logic [7:0] rev, input logic [15:0] mfr);
    case (pos)
      0:       return dev[15:8];
      1:       return dev[7:0];
      2:       return rev;
      3:       return mfr[15:8];
      default: return mfr[7:0];
    endcase
  endfunction

endpackage

// File: rtl/kcp_addr_decode.sv
module kcp_addr_decode #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 'h4E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              idx_hit,
  output logic              data_hit
);
  localparam logic [ADDR_W-1:0] STEP = 1;

  logic              alt_q;
  logic [ADDR_W-1:0] base;

  // Strap follows the pin only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) alt_q <= strap_alt;
  end

  assign base     = alt_q ? BASE_ALT : BASE_PRI;
  assign idx_hit  = (host_addr == base);
  assign data_hit = (host_addr == base + STEP);

endmodule

// File: rtl/kcp_key_fsm.sv
module kcp_key_fsm
  import kcp_pkg::*;
#(
  parameter logic [7:0] KEY_OPEN  = 8'h87,
  parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open,
  output logic       armed,
  output logic       enter_evt,
  output logic       leave_evt
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      KS_LOCKED: if (idx_wr) state_d = (wdata == KEY_OPEN) ? KS_ARMED : KS_LOCKED;
      KS_ARMED:  if (idx_wr) state_d = (wdata == KEY_OPEN) ? KS_OPEN  : KS_LOCKED;
      KS_OPEN:   if (idx_wr && wdata == KEY_CLOSE) state_d = KS_LOCKED;
      default:   state_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open      = (state_q == KS_OPEN);
  assign armed     = (state_q == KS_ARMED);
  assign enter_evt = armed && idx_wr && (wdata == KEY_OPEN);
  assign leave_evt = open && idx_wr && (wdata == KEY_CLOSE);

endmodule

// File: rtl/kcp_reg_bank.sv
module kcp_reg_bank
  import kcp_pkg::*;
#(
  parameter logic [7:0]  LDN_IDX  = 8'h07,
  parameter logic [7:0]  WIN_BASE = 8'h30,
  parameter logic [15:0] DEV_ID   = 16'h0A51,
  parameter logic [7:0]  DEV_REV  = 8'h01,
  parameter logic [15:0] MFR_ID   = 16'h1934
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open,
  input  logic       enter_evt,
  input  logic       idx_load,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  input  logic [7:0] win_rdata,
  output logic [7:0] index_q,
  output logic [7:0] ldn_q,
  output logic [7:0] cfg_rdata,
  output logic       win_we,
  output logic       win_re
);
  logic [7:0] id_table [ID_COUNT];
  logic [7:0] id_off;
  logic       id_hit;
  logic       window;

  for (genvar g = 0; g < ID_COUNT; g++) begin : g_id
    assign id_table[g] = id_byte(g, DEV_ID, DEV_REV, MFR_ID);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         index_q <= 8'h00;
    else if (enter_evt) index_q <= 8'h00;
    else if (idx_load)  index_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldn_q <= 8'h00;
    else if (open && data_wr && index_q == LDN_IDX) ldn_q <= wdata;
  end

  assign window = in_window(index_q, WIN_BASE);
  assign win_we = open && data_wr && window;
  assign win_re = open && data_rd && window;

  assign id_off = index_q - ID_FIRST;
  assign id_hit = (index_q >= ID_FIRST) && (int'(id_off) < ID_COUNT);

  always_comb begin
    cfg_rdata = 8'h00;
    if (window)                cfg_rdata = win_rdata;
    else if (index_q == LDN_IDX) cfg_rdata = ldn_q;
    else if (id_hit)           cfg_rdata = id_table[id_off[2:0]];
  end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import kcp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI  = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 'h4E,
  parameter logic [7:0]        KEY_OPEN  = 8'h87,
  parameter logic [7:0]        KEY_CLOSE = 8'hAA,
  parameter logic [7:0]        LDN_IDX   = 8'h07,
  parameter logic [7:0]        WIN_BASE  = 8'h30,
  parameter logic [15:0]       DEV_ID    = 16'h0A51,
  parameter logic [7:0]        DEV_REV   = 8'h01,
  parameter logic [15:0]       MFR_ID    = 16'h1934
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              cfg_mode,
  output logic [7:0]        win_ldn,
  output logic [7:0]        win_idx,
  output logic [7:0]        win_wdata,
  output logic              win_we,
  output logic              win_re,
  input  logic [7:0]        win_rdata
);
  // Named internal events, also watched by the checker.
  logic idx_hit, data_hit;
  logic idx_wr_evt, idx_rd_evt, data_wr_evt, data_rd_evt;
  logic key_armed, enter_evt, leave_evt, idx_load;
  logic [7:0] cfg_rdata;

  kcp_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .host_addr(host_addr),
    .idx_hit(idx_hit), .data_hit(data_hit)
  );

  assign idx_wr_evt  = host_wr && idx_hit;
  assign idx_rd_evt  = host_rd && idx_hit;
  assign data_wr_evt = host_wr && data_hit;
  assign data_rd_evt = host_rd && data_hit;

  kcp_key_fsm #(
    .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr_evt), .wdata(host_wdata),
    .open(cfg_mode), .armed(key_armed), .enter_evt(enter_evt), .leave_evt(leave_evt)
  );

  assign idx_load = cfg_mode && idx_wr_evt && !leave_evt;

  kcp_reg_bank #(
    .LDN_IDX(LDN_IDX), .WIN_BASE(WIN_BASE), .DEV_ID(DEV_ID),
    .DEV_REV(DEV_REV), .MFR_ID(MFR_ID)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .open(cfg_mode), .enter_evt(enter_evt),
    .idx_load(idx_load), .data_wr(data_wr_evt), .data_rd(data_rd_evt),
    .wdata(host_wdata), .win_rdata(win_rdata), .index_q(win_idx),
    .ldn_q(win_ldn), .cfg_rdata(cfg_rdata), .win_we(win_we), .win_re(win_re)
  );

  assign win_wdata = host_wdata;

  always_comb begin
    host_rdata = NO_RESPONSE;
    if (cfg_mode && idx_rd_evt)       host_rdata = win_idx;
    else if (cfg_mode && data_rd_evt) host_rdata = cfg_rdata;
  end

endmodule

// File: rtl/kcp_checker.sv
module kcp_checker #(
  parameter logic [7:0] KEY_OPEN  = 8'h87,
  parameter logic [7:0] KEY_CLOSE = 8'hAA,
  parameter logic [7:0] LDN_IDX   = 8'h07,
  parameter logic [7:0] WIN_BASE  = 8'h30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_mode,
  input logic       key_armed,
  input logic       idx_hit,
  input logic       data_hit,
  input logic       idx_wr_evt,
  input logic       data_wr_evt,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic [7:0] win_idx,
  input logic [7:0] win_ldn,
  input logic       win_we,
  input logic       win_re
);
  a_r1_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_hit && data_hit));

  a_r2_two_keys: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(key_armed && idx_wr_evt && host_wdata == KEY_OPEN));

  a_r3_single_write_stays_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && !key_armed && idx_wr_evt) |=> !cfg_mode);

  a_r4_closed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> (!win_we && !win_re && host_rdata == 8'hFF));

  a_r5_close_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && idx_wr_evt && host_wdata == KEY_CLOSE) |=> !cfg_mode);

  a_r6_index_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> win_idx == 8'h00);

  a_r7_ldn_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_mode && data_wr_evt && win_idx == LDN_IDX) |=> $stable(win_ldn));

  a_r9_window_range: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we || win_re) |-> (cfg_mode && win_idx >= WIN_BASE));

endmodule

bind keyed_cfg_port kcp_checker #(
  .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE), .LDN_IDX(LDN_IDX), .WIN_BASE(WIN_BASE)
) u_kcp_checker (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .key_armed(key_armed),
  .idx_hit(idx_hit), .data_hit(data_hit), .idx_wr_evt(idx_wr_evt),
  .data_wr_evt(data_wr_evt), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .win_idx(win_idx), .win_ldn(win_ldn), .win_we(win_we), .win_re(win_re)
);

// File: tb/keyed_cfg_port_bench.sv
`timescale 1ns/1ps
module keyed_cfg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic [15:0] host_addr = 16'h0000;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        cfg_mode;
  logic [7:0]  win_ldn, win_idx, win_wdata, win_rdata;
  logic        win_we, win_re;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // Reference model state
  int m_stage, m_idx, m_ldn, m_base;

  always #2.5 clk = ~clk;

  // Window responder: value derived from device and index.
  assign win_rdata = win_ldn * 8'd7 + win_idx;

  keyed_cfg_port #(.DEV_ID(16'h5A3C), .DEV_REV(8'h2B)) u_keyed_cfg_port (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cfg_mode(cfg_mode), .win_ldn(win_ldn),
    .win_idx(win_idx), .win_wdata(win_wdata), .win_we(win_we), .win_re(win_re),
    .win_rdata(win_rdata)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_read(input int idx);
    if (idx >= 'h30) return (m_ldn * 7 + idx) % 256;
    case (idx)
      'h07: return m_ldn;
      'h20: return 'h5A;
      'h21: return 'h3C;
      'h22: return 'h2B;
      'h23: return 'h19;
      'h24: return 'h34;
      default: return 0;
    endcase
  endfunction

  // One bus cycle: drive, compare against the model, then advance the model.
  task automatic step(input int a, input bit w, input bit r, input int d, input string tag);
    bit is_idx, is_dat, open;
    int exp_rd;
    bit exp_we, exp_re;
    @(negedge clk);
    host_addr = 16'(a); host_wr = w; host_rd = r; host_wdata = 8'(d);
    #1;
    is_idx = (a == m_base);
    is_dat = (a == m_base + 1);
    open   = (m_stage == 2);
    exp_rd = 'hFF;
    if (r && open && is_idx) exp_rd = m_idx;
    if (r && open && is_dat) exp_rd = model_read(m_idx);
    exp_we = w && open && is_dat && (m_idx >= 'h30);
    exp_re = r && open && is_dat && (m_idx >= 'h30);
    chk(tag, "cfg_mode", int'(cfg_mode), int'(open));
    chk(tag, "host_rdata", int'(host_rdata), exp_rd);
    chk(tag, "win_we", int'(win_we), int'(exp_we));
    chk(tag, "win_re", int'(win_re), int'(exp_re));
    chk(tag, "win_ldn", int'(win_ldn), m_ldn);
    chk(tag, "win_idx", int'(win_idx), m_idx);
    if (exp_we) chk(tag, "win_wdata", int'(win_wdata), d);
    @(posedge clk);
    if (w && is_idx) begin
      if (m_stage == 0)      m_stage = (d == 'h87) ? 1 : 0;
      else if (m_stage == 1) begin
        if (d == 'h87) begin m_stage = 2; m_idx = 0; end
        else m_stage = 0;
      end else if (d == 'hAA) m_stage = 0;
      else m_idx = d;
    end
    if (w && is_dat && open && m_idx == 'h07) m_ldn = d;
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst_n = 1'b0; strap_alt = s; host_wr = 1'b0; host_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_stage = 0; m_idx = 0; m_ldn = 0; m_base = s ? 'h4E : 'h2E;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    step('h2E, 0, 0, 0, "R7 reset state");
    // R4: closed port silent
    step('h2F, 0, 1, 0, "R4 closed data read");
    step('h2E, 0, 1, 0, "R4 closed index read");
    step('h2F, 1, 0, 'h33, "R4 closed data write");
    // R3: broken sequence, then data access does not restart it
    step('h2E, 1, 0, 'h87, "R3 first key");
    step('h2E, 1, 0, 'h12, "R3 wrong byte");
    step('h2E, 1, 0, 'h87, "R3 key again");
    step('h2F, 0, 1, 0, "R3 still closed");
    step('h2F, 1, 0, 'h44, "R3 data write between keys");
    step('h2E, 1, 0, 'h87, "R2 second key opens");
    // R6: index cleared on open
    step('h2E, 0, 1, 0, "R6 index zero");
    // R8: identification
    for (int i = 'h20; i <= 'h24; i++) begin
      step('h2E, 1, 0, i, "R8 select id");
      step('h2F, 0, 1, 0, "R8 read id");
    end
    step('h2E, 1, 0, 'h21, "R8 select id low");
    step('h2F, 1, 0, 'h00, "R8 write read-only");
    step('h2F, 0, 1, 0, "R8 id unchanged");
    // R10: unassigned index
    step('h2E, 1, 0, 'h10, "R10 select");
    step('h2F, 1, 0, 'h77, "R10 write");
    step('h2F, 0, 1, 0, "R10 read zero");
    // R7: selector
    step('h2E, 1, 0, 'h07, "R7 select ldn");
    step('h2F, 1, 0, 'h05, "R7 write ldn");
    step('h2F, 0, 1, 0, "R7 read ldn");
    // R9: window
    step('h2E, 1, 0, 'h30, "R9 window low edge");
    step('h2F, 1, 0, 'h9C, "R9 window write");
    step('h2F, 0, 1, 0, "R9 window read");
    step('h2E, 1, 0, 'hF0, "R9 select high");
    step('h2F, 0, 1, 0, "R9 window read high");
    step('h2E, 1, 0, 'h2F, "R9 below window");
    step('h2F, 1, 0, 'h11, "R9 no strobe below");
    step('h2E, 1, 0, 'h87, "R5 open key loads index");
    step('h2E, 0, 1, 0, "R6 index read back");
    // R1: wrong base ignored
    step('h4E, 1, 0, 'h07, "R1 other base write");
    step('h4F, 0, 1, 0, "R1 other base read");
    step('h2E, 0, 1, 0, "R1 index untouched");
    // R5: close
    step('h2E, 1, 0, 'hAA, "R5 close key");
    step('h2E, 0, 1, 0, "R5 closed");
    step('h2F, 1, 0, 'h66, "R4 write after close");
    // reopen, selector retained
    step('h2E, 1, 0, 'h87, "R2 key one");
    step('h2E, 1, 0, 'h87, "R2 key two");
    step('h2E, 0, 1, 0, "R6 index zero again");
    step('h2E, 1, 0, 'h07, "R7 select ldn");
    step('h2F, 0, 1, 0, "R7 ldn retained");
    step('h2E, 1, 0, 'hAA, "R5 close");
    // R1: alternate base
    do_reset(1'b1);
    step('h4E, 0, 0, 0, "R7 ldn after reset");
    step('h2E, 1, 0, 'h87, "R1 key at old base");
    step('h2E, 1, 0, 'h87, "R1 key at old base");
    step('h4F, 0, 1, 0, "R1 still closed");
    @(negedge clk) strap_alt = 1'b0;
    step('h4E, 1, 0, 'h87, "R1 key alt base");
    step('h4E, 1, 0, 'h87, "R1 key alt base");
    step('h4E, 1, 0, 'h23, "R1 select after strap change");
    step('h4F, 0, 1, 0, "R8 manufacturer high");
    step('h2F, 0, 1, 0, "R1 old data port silent");
    step('h4E, 1, 0, 'hAA, "R5 close alt");
    done = 1;
    summary();
    $finish;
  end
endmodule